// File: doc/BRIEF.md
# Interleaved-Channel Mismatch Compensation Filter Bank

A sampler built from four time-interleaved sub-converters produces one word per clock holding four signed 12-bit samples. Lane c of the word belongs to aggregate instant 4k+c. Each sub-converter has its own offset and its own frequency-dependent gain and timing error. This block removes a programmable offset from every lane. It then gives each lane's stream its own real-coefficient FIR filter, as if that stream had been raised to the aggregate rate by inserting zeros at the other three phases. The four filter results are added into one corrected aggregate-rate stream, emitted as four samples per clock.

Filter coefficients and offsets are register state, written at run time through a plain address/data/write-enable port. They are produced elsewhere, typically by fitting sine captures and inverting a channel matrix. The datapath is polyphase: taps that would only ever meet inserted zeros are never built, so each of the four output lanes draws on TAPS/4 taps from each channel.

Top module: `interleave_fir_comp`

## Requirements
- R1: During and straight after reset, outValid is 0 and outData is 0, and every coefficient and offset is zero. Words accepted with that state produce all-zero output samples.
- R2: If tap 0 of every channel holds 16384 (1.0 in signed Q1.14), every other tap holds 0 and all offsets are 0, then output lane p of each valid output word equals input lane p of the matching input word.
- R3: The offset of channel c, a signed 12-bit value, is subtracted from lane c of each accepted word before any filtering. The difference is kept at 13 bits with no loss.
- R4: Tap j of channel c weights the channel-c sample of aggregate instant 4k+c into output instant 4k+c+j, where output instant 4k'+p appears on lane p of output word k'. Taps that would fall on inserted zeros contribute nothing.
- R5: Each channel's coefficients act only on that channel's samples. A write to one channel's tap leaves the other channels' contributions unchanged.
- R6: Each output sample is the full-precision sum of the four channel filter contributions at that instant.
- R7: The sum, in units of 2^-14, is rounded half toward positive infinity to an integer, that is floor(sum/16384 + 1/2).
- R8: A rounded result above 2047 is output as 2047, and one below -2048 is output as -2048.
- R9: An input word accepted on a clock edge with inValid high appears, if it is valid, after the third rising edge counting the accepting edge, with outValid high for one cycle. History advances only on accepted words, so idle cycles between words do not change results.
- R10: Following reset, the first TAPS/4 accepted words (4 by default) yield no output word. Every later accepted word yields exactly one.
- R11: A configuration write takes effect only when cfgWe is high. cfgAddr bit AW-1 selects the region: 0 for a coefficient, 1 for an offset. Bits [TAPW+1:TAPW] give the channel and bits [TAPW-1:0] the tap. A coefficient takes all 16 bits of cfgData as signed Q1.14. An offset takes cfgData[11:0] as signed and ignores the tap bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word accepted on this edge |
| inData | input | 48 | Four signed 12-bit samples; lane c at bits [12c+11:12c] |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | AW (7) | Region, channel and tap select |
| cfgData | input | 16 | Coefficient (Q1.14) or offset (low 12 bits) |
| outValid | output | 1 | Output word is valid |
| outData | output | 48 | Four corrected signed 12-bit samples; lane p is instant 4k+p |

## Verification
The assertions take the control inputs, inValid and cfgWe, to be driven to known levels on every cycle after reset. They also expect any address presented with cfgWe high to decode to exactly one register. The scoreboard's reference computes each expected word from the coefficients that are current when the word is sent. For that reason the stimulus makes configuration writes only after the pipeline has drained, and it never writes while words are in flight. Input samples stay inside the signed 12-bit range, and offsets span the full range, so the 13-bit difference path is exercised at both ends.

// File: rtl/interleave_fir_pkg.sv
package interleave_fir_pkg;
  localparam int LANES = 4;
  localparam int CHW   = $clog2(LANES);

  typedef struct packed {
    logic             shift;
    logic [LANES-1:0] coefWr;
    logic [LANES-1:0] offWr;
  } dpStrobe_t;
endpackage

// File: rtl/interleave_fir_ctrl.sv
module interleave_fir_ctrl
  import interleave_fir_pkg::*;
#(
  parameter int TAPS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            cfgWe,
  input  logic            cfgRegion,
  input  logic [CHW-1:0]  cfgCh,
  output dpStrobe_t       strobe,
  output logic            outValid
);
  localparam int FILL = TAPS / LANES;
  localparam int CNTW = $clog2(FILL + 1);

  logic [CNTW-1:0] fillCnt;
  logic [2:0]      validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt   <= '0;
      validPipe <= '0;
    end else begin
      if (inValid && fillCnt != CNTW'(FILL)) fillCnt <= fillCnt + 1'b1;
      validPipe <= {validPipe[1:0], inValid && (fillCnt == CNTW'(FILL))};
    end
  end

  assign outValid = validPipe[2];

  always_comb begin
    strobe       = '0;
    strobe.shift = inValid;
    for (int ch = 0; ch < LANES; ch++) begin
      strobe.coefWr[ch] = cfgWe && !cfgRegion && (cfgCh == ch[CHW-1:0]);
      strobe.offWr[ch]  = cfgWe &&  cfgRegion && (cfgCh == ch[CHW-1:0]);
    end
  end

  // R9: a valid output always traces back to an accepted word three edges earlier
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));

  // R10: words accepted before the history is full never surface
  assert_no_early_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && fillCnt != CNTW'(FILL)) |-> ##3 !outValid);

  // R11: at most one register is written per cycle
  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.coefWr, strobe.offWr}));
endmodule

// File: rtl/interleave_fir_dp.sv
module interleave_fir_dp
  import interleave_fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 16,
  parameter int FRAC     = 14,
  parameter int TAPS     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [LANES*SAMPLE_W-1:0]   inData,
  input  logic [$clog2(TAPS)-1:0]     cfgTap,
  input  logic [COEF_W-1:0]           cfgData,
  output logic [LANES*SAMPLE_W-1:0]   outData
);
  localparam int PHASE_TAPS = TAPS / LANES;
  localparam int DEPTH      = PHASE_TAPS + 1;
  localparam int HW         = SAMPLE_W + 1;
  localparam int PRODW      = HW + COEF_W;
  localparam int ACCW       = PRODW + $clog2(TAPS);
  localparam int NTERM      = LANES * PHASE_TAPS;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] MINV = ACCW'(-(64'sd1 <<< (SAMPLE_W - 1)));

  logic signed [COEF_W-1:0]   coef [LANES][TAPS];
  logic signed [SAMPLE_W-1:0] offs [LANES];
  logic signed [HW-1:0]       hist [LANES][DEPTH];
  logic signed [HW-1:0]       diff [LANES];

  always_comb begin
    for (int ch = 0; ch < LANES; ch++)
      diff[ch] = HW'($signed(inData[ch*SAMPLE_W +: SAMPLE_W])) - HW'(offs[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < LANES; ch++) begin
        offs[ch] <= '0;
        for (int t = 0; t < TAPS; t++)  coef[ch][t] <= '0;
        for (int d = 0; d < DEPTH; d++) hist[ch][d] <= '0;
      end
    end else begin
      for (int ch = 0; ch < LANES; ch++) begin
        if (strobe.coefWr[ch]) coef[ch][cfgTap] <= cfgData;
        if (strobe.offWr[ch])  offs[ch] <= cfgData[SAMPLE_W-1:0];
        if (strobe.shift) begin
          hist[ch][0] <= diff[ch];
          for (int d = 1; d < DEPTH; d++) hist[ch][d] <= hist[ch][d-1];
        end
      end
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : gLane
    logic signed [ACCW-1:0]   terms [NTERM];
    logic signed [ACCW-1:0]   accSum, accReg, rounded;
    logic [SAMPLE_W-1:0]      satVal, laneOut;

    for (genvar c = 0; c < LANES; c++) begin : gCh
      for (genvar m = 0; m < PHASE_TAPS; m++) begin : gTap
        localparam int TIDX = ((p - c + LANES) % LANES) + LANES * m;
        localparam int BACK = m + ((p < c) ? 1 : 0);
        logic signed [PRODW-1:0] prod;
        assign prod = PRODW'(coef[c][TIDX]) * PRODW'(hist[c][BACK]);
        assign terms[c*PHASE_TAPS + m] = ACCW'(prod);
      end
    end

    always_comb begin
      accSum = '0;
      for (int t = 0; t < NTERM; t++) accSum = accSum + terms[t];
    end

    always_comb begin
      rounded = (accReg + HALF) >>> FRAC;
      if (rounded > MAXV)      satVal = MAXV[SAMPLE_W-1:0];
      else if (rounded < MINV) satVal = MINV[SAMPLE_W-1:0];
      else                     satVal = rounded[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accReg  <= '0;
        laneOut <= '0;
      end else begin
        accReg  <= accSum;
        laneOut <= satVal;
      end
    end

    assign outData[p*SAMPLE_W +: SAMPLE_W] = laneOut;
  end

  // R9: history is frozen on cycles without an accepted word
  assert_hold_history_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> ($stable(hist[0][0]) && $stable(hist[LANES-1][DEPTH-1])));

  for (genvar c = 0; c < LANES; c++) begin : gOffChk
    // R11: an offset write lands the low data bits in that channel's register
    assert_offset_write_R11: assert property (@(posedge clk) disable iff (!rstN)
      strobe.offWr[c] |=> (offs[c] == $past(cfgData[SAMPLE_W-1:0])));
  end
endmodule

// File: rtl/interleave_fir_comp.sv
module interleave_fir_comp
  import interleave_fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 16,
  parameter int FRAC     = 14,
  parameter int TAPS     = 16,
  parameter int AW       = 1 + CHW + $clog2(TAPS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [LANES*SAMPLE_W-1:0]  inData,
  input  logic                       cfgWe,
  input  logic [AW-1:0]              cfgAddr,
  input  logic [COEF_W-1:0]          cfgData,
  output logic                       outValid,
  output logic [LANES*SAMPLE_W-1:0]  outData
);
  localparam int TAPW = $clog2(TAPS);

  dpStrobe_t strobe;

  interleave_fir_ctrl #(.TAPS(TAPS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .cfgWe     (cfgWe),
    .cfgRegion (cfgAddr[AW-1]),
    .cfgCh     (cfgAddr[TAPW +: CHW]),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  interleave_fir_dp #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .FRAC     (FRAC),
    .TAPS     (TAPS)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .cfgTap  (cfgAddr[TAPW-1:0]),
    .cfgData (cfgData),
    .outData (outData)
  );
endmodule

// File: tb/interleave_fir_comp_test.sv
module interleave_fir_comp_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 16;
  localparam int FILL = TAPS / 4;
  localparam int MAXW = 512;

  typedef struct {
    logic [47:0] word;
    int          due;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [47:0] inData = '0;
  logic        cfgWe = 1'b0;
  logic [6:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        outValid;
  logic [47:0] outData;

  interleave_fir_comp uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  item_t       sb[$];
  longint      coefM [4][TAPS];
  longint      offM  [4];
  longint      subM  [4][MAXW];
  int          wordCnt = 0;
  int          cycleCnt = 0;
  int          tests = 0;
  int          fails = 0;
  int          validSeen = 0;
  int unsigned lfsr = 32'h1234_5678;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'($signed(lfsr[11:0]));
  endfunction

  // Zero-stuffed reference: output instant n sums h_c[j] * u_c[n-j]
  function automatic longint modelLane(int k, int p);
    longint acc = 0;
    int n = 4 * k + p;
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < TAPS; j++) begin
        int t = n - j;
        if (t >= 0 && (t % 4) == c) acc += coefM[c][j] * subM[c][t / 4];
      end
    return acc;
  endfunction

  function automatic logic [11:0] roundSat(longint acc);
    longint r = (acc + 64'sd8192) >>> 14;
    if (r > 2047)  r = 2047;
    if (r < -2048) r = -2048;
    return r[11:0];
  endfunction

  task automatic sendWord(input int x0, input int x1, input int x2, input int x3,
                          input string tag);
    int xs[4] = '{x0, x1, x2, x3};
    item_t it;
    for (int c = 0; c < 4; c++) begin
      inData[c*12 +: 12] = xs[c][11:0];
      subM[c][wordCnt] = longint'(xs[c]) - offM[c];
    end
    inValid = 1'b1;
    if (wordCnt >= FILL) begin
      for (int p = 0; p < 4; p++) it.word[p*12 +: 12] = roundSat(modelLane(wordCnt, p));
      it.due = cycleCnt + 3;
      it.tag = tag;
      sb.push_back(it);
    end
    wordCnt++;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic cfgWrite(input bit region, input int ch, input int tap, input int data);
    cfgAddr = {region, 2'(ch), 4'(tap)};
    cfgData = 16'(data);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    if (region) offM[ch] = longint'($signed(cfgData[11:0]));
    else        coefM[ch][tap] = longint'($signed(cfgData));
  endtask

  task automatic clearCoefs();
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < TAPS; j++) cfgWrite(1'b0, c, j, 0);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  // Monitor: pop and compare as the design produces words
  always @(negedge clk) begin
    item_t it;
    if (rstN && outValid) begin
      validSeen++;
      if (sb.size() == 0) chk(1'b0, "R10", "unexpected output word", 1, 0);
      else begin
        it = sb.pop_front();
        chk(outData === it.word, it.tag, "output word", longint'(outData), longint'(it.word));
        chk(cycleCnt == it.due, "R9", "output cycle", cycleCnt, it.due);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      offM[c] = 0;
      for (int j = 0; j < TAPS; j++) coefM[c][j] = 0;
    end
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(outData == '0, "R1", "outData after reset", longint'(outData), 0);

    // R10: history fill produces nothing
    for (int i = 0; i < FILL; i++) sendWord(100 + i, -200, 300, -400, "R10");
    drain();
    chk(validSeen == 0, "R10", "outputs during fill", validSeen, 0);
    // R1: reset coefficients give zero output
    sendWord(2047, -2048, 1234, -999, "R1");
    sendWord(5, 6, 7, 8, "R1");
    drain();

    // R2: unit impulse at tap 0 merges lanes in order
    for (int c = 0; c < 4; c++) cfgWrite(1'b0, c, 0, 16384);
    sendWord(1, 2, 3, 4, "R2");
    sendWord(2047, -2048, 2047, -2048, "R2");
    for (int i = 0; i < 6; i++) sendWord(rnd(), rnd(), rnd(), rnd(), "R2");
    drain();

    // R3 and R11: offsets written with nonzero tap bits
    cfgWrite(1'b1, 0, 5, 100);
    cfgWrite(1'b1, 1, 15, -50);
    cfgWrite(1'b1, 2, 3, 2047);
    cfgWrite(1'b1, 3, 9, -2048);
    sendWord(0, 0, 0, 0, "R3");
    sendWord(2047, -2048, -2048, 2047, "R3");
    for (int i = 0; i < 4; i++) sendWord(rnd(), rnd(), rnd(), rnd(), "R3");
    drain();

    // R11: write port ignored when cfgWe is low
    cfgAddr = {1'b1, 2'd0, 4'd0};
    cfgData = 16'h07FF;
    cfgWe = 1'b0;
    @(negedge clk);
    cfgAddr = {1'b0, 2'd1, 4'd0};
    cfgData = 16'h0000;
    @(negedge clk);
    sendWord(500, 600, 700, 800, "R11");
    sendWord(-1, -2, -3, -4, "R11");
    drain();
    for (int c = 0; c < 4; c++) cfgWrite(1'b1, c, 0, 0);

    // R4: tap placement across phases and words
    clearCoefs();
    cfgWrite(1'b0, 2, 5, 16384);
    cfgWrite(1'b0, 3, 2, 16384);
    cfgWrite(1'b0, 0, 0, -8192);
    for (int i = 0; i < 8; i++) sendWord(rnd(), rnd(), rnd(), rnd(), "R4");
    drain();

    // R5 R6: independent filters on every channel, summed
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < TAPS; j++) cfgWrite(1'b0, c, j, (((c*7 + j*13) % 41) - 20) * 300);
    for (int i = 0; i < 10; i++) sendWord(rnd(), rnd(), rnd(), rnd(), "R5 R6");
    drain();
    cfgWrite(1'b0, 1, 4, 9000);
    for (int i = 0; i < 5; i++) sendWord(rnd(), rnd(), rnd(), rnd(), "R5");
    drain();

    // R9: idle gaps between accepted words
    for (int i = 0; i < 10; i++) begin
      sendWord(rnd(), rnd(), rnd(), rnd(), "R9");
      repeat (i % 4) @(negedge clk);
    end
    drain();

    // R7: half-up rounding with gain 0.5
    clearCoefs();
    for (int c = 0; c < 4; c++) cfgWrite(1'b0, c, 0, 8192);
    sendWord(3, -3, 1, -1, "R7");
    sendWord(2047, -2048, 5, -5, "R7");
    drain();

    // R8: saturation with gain near 2
    for (int c = 0; c < 4; c++) cfgWrite(1'b0, c, 0, 32767);
    sendWord(2047, -2048, 100, -1000, "R8");
    sendWord(1100, -1100, 1023, -1025, "R8");
    drain();

    chk(sb.size() == 0, "R9", "pending expected words", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule